// File: doc/BRIEF.md
# Memory Space Access Router

This block sits between an 8-bit processor core and its memories. For every request from the core it picks one memory target and asserts that target's select. The targets are on-chip code ROM, external code memory, low data RAM, high data RAM, the special-function register file, on-chip auxiliary RAM and external data memory. The choice depends on three things: the access class the core reports, the address, and two mode bits. One mode bit is an external-access pin that is captured only while reset is held. The other is a configuration bit that maps the auxiliary RAM in or out. For external data and code cycles the block also produces the drive enables and values for the low (address/data multiplexed) port and the high address port, plus the external read and write strobes. The bus cycle timing itself is left to the core.

Requests arrive on a valid/ready stream. `req_ready` is high whenever reset is released, so the router never applies back-pressure in normal operation. A request is taken in any cycle where both `req_valid` and `req_ready` are high. Every output for that request is combinational in the same cycle. While reset is held, `req_ready` is low, no select is raised and any request is dropped. The configuration input is registered, so a new value steers requests from the cycle after the clock edge that samples it.

Top module: `mem_route`

## Requirements
- R1: `ext_code_pin` is captured into the router on every clock edge while `rst_n` is low; once reset is released, changes on the pin have no effect on routing.
- R2: With the captured pin high, a code fetch (class 0) at 0000h..3FFFh selects on-chip ROM (`tgt_sel` bit 0), and at 4000h..FFFFh selects external code (bit 1), driving both address ports and `code_rd`.
- R3: With the captured pin low, every code fetch selects external code (bit 1) whatever the address.
- R4: A direct (class 1) or indirect (class 2) access whose low address byte is 00h..7Fh selects low RAM (bit 2); the high address byte is ignored.
- R5: For low address byte 80h..FFh, direct access selects the register file (bit 4) and indirect access selects high RAM (bit 3).
- R6: With the registered configuration bit 0, a register-pointer external move (class 3) selects auxiliary RAM (bit 5); a 16-bit-pointer move (class 4) selects auxiliary RAM at 0000h..00FFh and external data (bit 6) at 0100h..FFFFh.
- R7: An auxiliary RAM access drives neither address port, nor the write data, and raises neither `bus_rd` nor `bus_wr`.
- R8: With the configuration bit 1, classes 3 and 4 both select external data. Class 3 drives only the low port with the low address byte. Class 4 drives the high port with the high byte and the low port with the low byte.
- R9: A stack access (class 5) selects only low RAM (low byte below 80h) or high RAM; it never reaches auxiliary RAM, whatever the configuration.
- R10: An accepted request with class 0..5 raises exactly one select and no error; class 6 or 7 raises `req_err` and no select; with no accepted request all selects and `req_err` are low.
- R11: The registered configuration bit is 0 after reset and follows `aux_off_in` from the next clock edge.
- R12: An external data access copies `req_rd`/`req_wr` onto `bus_rd`/`bus_wr` and drives `bus_wdata` (with `bus_wdata_oe`) only on a write; `req_ready` is low exactly while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_code_pin | input | 1 | External-access pin, captured during reset |
| aux_off_in | input | 1 | 1 maps auxiliary RAM out, registered |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (high out of reset) |
| req_class | input | 3 | 0 fetch, 1 direct, 2 indirect, 3 ext move 8-bit pointer, 4 ext move 16-bit pointer, 5 stack |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| tgt_sel | output | 7 | One-hot target: 0 ROM, 1 ext code, 2 low RAM, 3 high RAM, 4 registers, 5 aux RAM, 6 ext data |
| req_err | output | 1 | Undefined class accepted |
| bus_lo_oe | output | 1 | Low port drives an address |
| bus_lo_addr | output | 8 | Low address byte, zero when not driven |
| bus_hi_oe | output | 1 | High port drives an address |
| bus_hi_addr | output | 8 | High address byte, zero when not driven |
| bus_wdata_oe | output | 1 | Low port drives write data |
| bus_wdata | output | 8 | Write data, zero when not driven |
| bus_rd | output | 1 | External data read strobe |
| bus_wr | output | 1 | External data write strobe |
| code_rd | output | 1 | External code fetch strobe |

## Verification
Two collisions need care. The first is a change of the configuration bit landing on the same clock edge as an external move. The bench changes `aux_off_in` half a cycle before an edge and issues a class 3 request on both sides of that edge. It expects the auxiliary RAM select before the edge and the external data select after it. The second is reset release coinciding with a toggle of the external-access pin. The bench raises the pin right after reset goes high and judges that code fetches still follow the value held during reset.

// File: rtl/mem_route_pkg.sv
package mem_route_pkg;
  typedef enum logic [2:0] {
    CLS_FETCH  = 3'd0,
    CLS_DIRECT = 3'd1,
    CLS_INDIR  = 3'd2,
    CLS_XPAGE  = 3'd3,
    CLS_XLONG  = 3'd4,
    CLS_STACK  = 3'd5
  } acc_class_e;

  localparam int TGT_N     = 7;
  localparam int T_IROM    = 0;
  localparam int T_XCODE   = 1;
  localparam int T_LORAM   = 2;
  localparam int T_HIRAM   = 3;
  localparam int T_REGS    = 4;
  localparam int T_AUX     = 5;
  localparam int T_XDATA   = 6;
endpackage

// File: rtl/mem_route_mode.sv
module mem_route_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_code_pin,
  input  logic aux_off_in,
  output logic ea_q,
  output logic cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q  <= ext_code_pin;
      cfg_q <= 1'b0;
    end else begin
      cfg_q <= aux_off_in;
    end
  end
endmodule

// File: rtl/mem_route_decode.sv
module mem_route_decode
  import mem_route_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ROM_BYTES = 16384,
  parameter int AUX_BYTES = 256,
  parameter int LO_BYTES  = 128
) (
  input  logic              go,
  input  logic [2:0]        cls,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ea_q,
  input  logic              cfg_q,
  output logic [TGT_N-1:0]  sel,
  output logic              err
);
  localparam int LO_W = $clog2(LO_BYTES);

  logic [7:0] byte_lo;
  logic       in_lo, in_rom, in_aux;

  assign byte_lo = addr[7:0];
  assign in_lo   = (byte_lo[7:LO_W] == '0);
  assign in_rom  = ({16'd0, addr} < 32'(ROM_BYTES));
  assign in_aux  = ({16'd0, addr} < 32'(AUX_BYTES));

  always_comb begin
    sel = '0;
    err = 1'b0;
    if (go) begin
      case (cls)
        CLS_FETCH:  sel[(ea_q && in_rom) ? T_IROM : T_XCODE] = 1'b1;
        CLS_DIRECT: sel[in_lo ? T_LORAM : T_REGS] = 1'b1;
        CLS_INDIR,
        CLS_STACK:  sel[in_lo ? T_LORAM : T_HIRAM] = 1'b1;
        CLS_XPAGE:  sel[cfg_q ? T_XDATA : T_AUX] = 1'b1;
        CLS_XLONG:  sel[(!cfg_q && in_aux) ? T_AUX : T_XDATA] = 1'b1;
        default:    err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mem_route_bus.sv
module mem_route_bus
  import mem_route_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [TGT_N-1:0]  sel,
  input  logic [2:0]        cls,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              wr,
  output logic              lo_oe,
  output logic [7:0]        lo_addr,
  output logic              hi_oe,
  output logic [ADDR_W-9:0] hi_addr,
  output logic              wd_oe,
  output logic [DATA_W-1:0] wd,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic              code_rd
);
  logic xdata, xcode, wide;

  assign xdata   = sel[T_XDATA];
  assign xcode   = sel[T_XCODE];
  assign wide    = xcode || (xdata && cls != 3'(CLS_XPAGE));

  assign lo_oe   = xdata || xcode;
  assign lo_addr = lo_oe ? addr[7:0] : 8'd0;
  assign hi_oe   = wide;
  assign hi_addr = wide ? addr[ADDR_W-1:8] : '0;
  assign ext_rd  = xdata && rd;
  assign ext_wr  = xdata && wr;
  assign wd_oe   = xdata && wr;
  assign wd      = wd_oe ? wdata : '0;
  assign code_rd = xcode;
endmodule

// File: rtl/mem_route.sv
module mem_route
  import mem_route_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ROM_BYTES = 16384,
  parameter int AUX_BYTES = 256,
  parameter int LO_BYTES  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_code_pin,
  input  logic              aux_off_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_class,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_rd,
  input  logic              req_wr,
  output logic [TGT_N-1:0]  tgt_sel,
  output logic              req_err,
  output logic              bus_lo_oe,
  output logic [7:0]        bus_lo_addr,
  output logic              bus_hi_oe,
  output logic [ADDR_W-9:0] bus_hi_addr,
  output logic              bus_wdata_oe,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              code_rd
);
  logic ea_q, cfg_q, go;

  assign req_ready = rst_n;
  assign go        = req_valid && req_ready;

  mem_route_mode u_mode (
    .clk(clk), .rst_n(rst_n), .ext_code_pin(ext_code_pin),
    .aux_off_in(aux_off_in), .ea_q(ea_q), .cfg_q(cfg_q)
  );

  mem_route_decode #(
    .ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES),
    .AUX_BYTES(AUX_BYTES), .LO_BYTES(LO_BYTES)
  ) u_dec (
    .go(go), .cls(req_class), .addr(req_addr), .ea_q(ea_q),
    .cfg_q(cfg_q), .sel(tgt_sel), .err(req_err)
  );

  mem_route_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .sel(tgt_sel), .cls(req_class), .addr(req_addr), .wdata(req_wdata),
    .rd(req_rd), .wr(req_wr), .lo_oe(bus_lo_oe), .lo_addr(bus_lo_addr),
    .hi_oe(bus_hi_oe), .hi_addr(bus_hi_addr), .wd_oe(bus_wdata_oe),
    .wd(bus_wdata), .ext_rd(bus_rd), .ext_wr(bus_wr), .code_rd(code_rd)
  );
endmodule

// File: rtl/mem_route_chk.sv
module mem_route_chk
  import mem_route_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_class,
  input logic [TGT_N-1:0] tgt_sel,
  input logic             req_err,
  input logic             bus_lo_oe,
  input logic             bus_hi_oe,
  input logic             bus_wdata_oe,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             ea_q,
  input logic             cfg_q
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R1: captured pin stays put once out of reset
  assert_ea_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ea_q));

  // R6: register-pointer move lands in aux RAM when mapped in
  assert_aux_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_class == 3'd3 && !cfg_q) |-> tgt_sel[T_AUX]);

  // R7: aux accesses stay off the external bus
  assert_aux_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[T_AUX] |-> !(bus_lo_oe || bus_hi_oe || bus_wdata_oe || bus_rd || bus_wr));

  // R9: stack never leaves internal RAM
  assert_stack_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_class == 3'd5) |-> (tgt_sel[T_LORAM] || tgt_sel[T_HIRAM]));

  // R10: exactly one select for a defined class
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_class <= 3'd5) |-> ($countones(tgt_sel) == 1 && !req_err));

  // R10: undefined class flags an error and selects nothing
  assert_bad_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_class > 3'd5) |-> (tgt_sel == '0 && req_err));

  // R10: idle cycles carry no select
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> (tgt_sel == '0 && !req_err));

  // R11: configuration bit is clear on the first cycle out of reset
  assert_cfg_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !cfg_q);
endmodule

bind mem_route mem_route_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_class(req_class), .tgt_sel(tgt_sel), .req_err(req_err),
  .bus_lo_oe(bus_lo_oe), .bus_hi_oe(bus_hi_oe), .bus_wdata_oe(bus_wdata_oe),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .ea_q(ea_q), .cfg_q(cfg_q)
);

// File: tb/mem_route_bench.sv
module mem_route_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_code_pin = 1'b1;
  logic aux_off_in = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_class = 3'd0;
  logic [15:0] req_addr = 16'd0;
  logic [7:0] req_wdata = 8'h5A;
  logic req_rd = 1'b0, req_wr = 1'b0;
  logic [6:0] tgt_sel;
  logic req_err, bus_lo_oe, bus_hi_oe, bus_wdata_oe, bus_rd, bus_wr, code_rd;
  logic [7:0] bus_lo_addr, bus_hi_addr, bus_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_route u_mem_route (
    .clk(clk), .rst_n(rst_n), .ext_code_pin(ext_code_pin), .aux_off_in(aux_off_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_class(req_class),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rd(req_rd), .req_wr(req_wr),
    .tgt_sel(tgt_sel), .req_err(req_err), .bus_lo_oe(bus_lo_oe),
    .bus_lo_addr(bus_lo_addr), .bus_hi_oe(bus_hi_oe), .bus_hi_addr(bus_hi_addr),
    .bus_wdata_oe(bus_wdata_oe), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .code_rd(code_rd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {class[3], addr[16], cfg, wr, rd, sel[7], err, lo_oe, hi_oe}
  localparam int NV = 21;
  localparam logic [31:0] VEC [NV] = '{
    {3'd0, 16'h0000, 3'b000, 7'b0000001, 3'b000}, // R2
    {3'd0, 16'h3FFF, 3'b000, 7'b0000001, 3'b000}, // R2
    {3'd0, 16'h4000, 3'b000, 7'b0000010, 3'b011}, // R2
    {3'd0, 16'hFFFF, 3'b000, 7'b0000010, 3'b011}, // R2
    {3'd1, 16'h007F, 3'b000, 7'b0000100, 3'b000}, // R4
    {3'd2, 16'h0000, 3'b000, 7'b0000100, 3'b000}, // R4
    {3'd1, 16'h0080, 3'b000, 7'b0010000, 3'b000}, // R5
    {3'd2, 16'h00A0, 3'b000, 7'b0001000, 3'b000}, // R5
    {3'd1, 16'h00A0, 3'b000, 7'b0010000, 3'b000}, // R5
    {3'd3, 16'h00A0, 3'b001, 7'b0100000, 3'b000}, // R6 R7
    {3'd4, 16'h00FF, 3'b010, 7'b0100000, 3'b000}, // R6 R7
    {3'd4, 16'h0100, 3'b001, 7'b1000000, 3'b011}, // R6 R12
    {3'd4, 16'hFFFF, 3'b010, 7'b1000000, 3'b011}, // R6 R12
    {3'd3, 16'h0042, 3'b101, 7'b1000000, 3'b010}, // R8
    {3'd4, 16'h0010, 3'b110, 7'b1000000, 3'b011}, // R8
    {3'd5, 16'h0050, 3'b000, 7'b0000100, 3'b000}, // R9
    {3'd5, 16'h00F0, 3'b100, 7'b0001000, 3'b000}, // R9
    {3'd5, 16'h1234, 3'b000, 7'b0000100, 3'b000}, // R9
    {3'd6, 16'h0000, 3'b000, 7'b0000000, 3'b100}, // R10
    {3'd7, 16'h0000, 3'b000, 7'b0000000, 3'b100}, // R10
    {3'd2, 16'h12C0, 3'b000, 7'b0001000, 3'b000}  // R4 R5
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    // reset state, R12
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_class = 3'd1; #2;
    check("R12 ready in reset", {31'd0, req_ready}, 32'd0);
    check("R10 no select in reset", {24'd0, tgt_sel, req_err}, 32'd0);
    @(negedge clk); rst_n = 1'b1; req_valid = 1'b0;
    #2 check("R12 ready out of reset", {31'd0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      @(negedge clk); aux_off_in = v[12]; req_valid = 1'b0;
      @(negedge clk);
      req_class = v[31:29]; req_addr = v[28:13]; req_wr = v[11]; req_rd = v[10];
      req_valid = 1'b1;
      #2;
      check($sformatf("R10 vec%0d sel/err", i), {24'd0, tgt_sel, req_err}, {24'd0, v[9:2]});
      check($sformatf("R7 R8 vec%0d port oe", i), {30'd0, bus_lo_oe, bus_hi_oe}, {30'd0, v[1:0]});
      check($sformatf("R12 vec%0d strobes", i), {29'd0, bus_rd, bus_wr, bus_wdata_oe},
            {29'd0, v[9] & v[10], v[9] & v[11], v[9] & v[11]});
    end

    // R8 address bytes and write data on a wide external move
    @(negedge clk); aux_off_in = 1'b1;
    @(negedge clk); req_class = 3'd4; req_addr = 16'h12AB; req_wr = 1'b1; req_rd = 1'b0; #2;
    check("R8 hi/lo address", {16'd0, bus_hi_addr, bus_lo_addr}, 32'h12AB);
    check("R12 write data", {24'd0, bus_wdata}, 32'h5A);
    // R8 narrow move leaves high port at zero
    req_class = 3'd3; req_addr = 16'h77CD; #2;
    check("R8 narrow hi idle", {16'd0, bus_hi_addr, bus_lo_addr}, 32'h00CD);
    // R9 stack with aux mapped out still internal
    req_class = 3'd5; req_addr = 16'h0010; req_wr = 1'b0; #2;
    check("R9 stack cfg1", {25'd0, tgt_sel}, 32'h04);
    // R10 idle
    req_valid = 1'b0; #2;
    check("R10 idle", {24'd0, tgt_sel, req_err}, 32'd0);

    // R11 config change on the edge of an external move
    @(negedge clk); aux_off_in = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_class = 3'd3; aux_off_in = 1'b1; #2;
    check("R11 before edge aux", {25'd0, tgt_sel}, 32'h20);
    @(negedge clk); #2;
    check("R11 after edge xdata", {25'd0, tgt_sel}, 32'h40);

    // R1 R3 R11: reset with pin low and config input high
    @(negedge clk); rst_n = 1'b0; ext_code_pin = 1'b0; aux_off_in = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; req_valid = 1'b1; req_class = 3'd3; req_addr = 16'h0001; #2;
    check("R11 config reset value", {25'd0, tgt_sel}, 32'h20);
    ext_code_pin = 1'b1;
    req_class = 3'd0; req_addr = 16'h0000; #2;
    check("R3 pin low fetch low", {25'd0, tgt_sel}, 32'h02);
    @(negedge clk); @(negedge clk); #2;
    check("R1 live pin ignored", {25'd0, tgt_sel}, 32'h02);
    check("R3 code strobe", {31'd0, code_rd}, 32'd1);
    req_class = 3'd3; #2;
    check("R11 config follows input", {25'd0, tgt_sel}, 32'h40);

    // R1 re-capture high, then drop pin
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1; ext_code_pin = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_class = 3'd0; req_addr = 16'h2000; #2;
    check("R1 R2 captured high", {25'd0, tgt_sel}, 32'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule